// File: doc/BRIEF.md
# Coprocessor register transfer handshake

This block is the coprocessor side of register-to-register moves between a pipelined host CPU and a small bank of coprocessor registers. The host announces an instruction with an active-low request strobe and a 32-bit instruction word. A second request strobe in the next cycle moves the instruction into execute, where the host also signals whether the instruction's condition passed. The block answers on two 2-bit handshake buses. One carries the decode-stage answer and the other carries the answers for later execute cycles. A fixed number of busy-wait cycles can be inserted before the final answer.

Once the host sees the final answer, the instruction is committed and moves through the memory and write stages. A move from the coprocessor presents register data during the memory stage. A move to the coprocessor takes the host's data-out bus during the write stage and stores it in the addressed register. Only one instruction is tracked at a time. Requests that arrive while a transfer is in flight are not taken.

Top module: `cpxfer_top`

## Requirements
- R1: After reset, both handshake buses read 2'b00 (ABSENT), the read-data bus is zero, and every coprocessor register reads back as zero.
- R2: In the first execute cycle (the cycle after the request strobe is seen low while idle), the decode bus answers ABSENT (2'b00) when instruction bits 11:8 differ from COPROC_ID or when bits 19:16 index beyond the register count. Otherwise it answers WAIT (2'b01) when BUSY_WAIT > 0, or LAST (2'b11) when BUSY_WAIT = 0. In every other cycle the decode bus reads ABSENT.
- R3: If the request strobe is high or the condition-pass input is low in the first execute cycle, the instruction is dropped: no further handshake, no read data and no register change.
- R4: An accepted instruction sees exactly BUSY_WAIT WAIT answers before LAST. The first of these is on the decode bus and the rest are on the execute bus in consecutive cycles. LAST follows on the execute bus.
- R5: For a write (instruction bit 20 = 0), the value on the write-data bus in the write stage is stored in register bits 19:16. The write stage is the second cycle after the cycle in which LAST was shown.
- R6: For a read (instruction bit 20 = 1), the read-data bus carries register bits 19:16 during the memory stage, which is the cycle after LAST. The bus is zero in every other cycle.
- R7: Values on the write-data bus in any cycle other than a committed write's write stage leave the registers unchanged.
- R8: Request strobes during the memory or write stage of a transfer are ignored and start no new transfer.
- R9: The two handshake buses are never non-ABSENT in the same cycle. The execute bus reads ABSENT outside busy-wait execute cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqN | input | 1 | Active-low instruction request strobe |
| instr | input | 32 | Instruction word, valid with the first request |
| condPass | input | 1 | Condition passed, sampled in the first execute cycle |
| wrData | input | 32 | Host data-out bus, sampled in the write stage |
| hsDec | output | 2 | Decode-stage handshake answer |
| hsEx | output | 2 | Execute-stage handshake answer |
| rdData | output | 32 | Read data, valid in the memory stage, else zero |

## Verification
The bench builds the block with BUSY_WAIT = 3, the largest count the two-bit encoding allows, so that the longest execute window (one decode WAIT followed by two execute WAITs) is covered. It keeps eight registers and COPROC_ID = 4'hA. Every register index is swept through writes and read-backs. All out-of-range indices 8 to 15 and a foreign coprocessor number are tried and must answer ABSENT. Dropped instructions are checked when condPass is low. Write-bus noise in the off-stage cycles and requests jammed into the memory and write stages must leave the register file unchanged, as seen through later reads.

// File: rtl/cpxfer_pkg.sv
package cpxfer_pkg;

  typedef enum logic [1:0] {
    HS_ABSENT = 2'b00,
    HS_WAIT   = 2'b01,
    HS_GO     = 2'b10,
    HS_LAST   = 2'b11
  } hsCode_t;

  localparam int MAX_BUSY_WAIT = 3;
  localparam int REG_IDX_W     = 4;

  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic [REG_IDX_W-1:0] idx;
  } strobes_t;

endpackage

// File: rtl/cpxfer_ctrl.sv
module cpxfer_ctrl
  import cpxfer_pkg::*;
#(
  parameter int         NUM_REGS  = 8,
  parameter logic [3:0] COPROC_ID = 4'hA,
  parameter int         BUSY_WAIT = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqN,
  input  logic [31:0] instr,
  input  logic        condPass,
  output hsCode_t     hsDec,
  output hsCode_t     hsEx,
  output strobes_t    strobes
);

  localparam int CNT_W = $clog2(MAX_BUSY_WAIT + 1);
  localparam logic [CNT_W-1:0] WAIT_LOAD =
    (BUSY_WAIT > 0) ? CNT_W'(BUSY_WAIT - 1) : '0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC1, ST_EXECW, ST_MEM, ST_WRITE
  } state_t;

  state_t                 state, stateNext;
  logic [CNT_W-1:0]       waitCnt;
  logic [3:0]             cpNumQ;
  logic [REG_IDX_W-1:0]   regIdxQ;
  logic                   isReadQ;
  logic                   match;
  logic                   unusedInstrBits;

  assign unusedInstrBits = ^{instr[31:21], instr[15:12], instr[7:0]};

  assign match = (cpNumQ == COPROC_ID) && (int'(regIdxQ) < NUM_REGS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      cpNumQ  <= '0;
      regIdxQ <= '0;
      isReadQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && !reqN) begin
        cpNumQ  <= instr[11:8];
        regIdxQ <= instr[19:16];
        isReadQ <= instr[20];
      end
      if (state == ST_EXEC1) begin
        waitCnt <= WAIT_LOAD;
      end else if (state == ST_EXECW && waitCnt != '0) begin
        waitCnt <= waitCnt - 1'b1;
      end
    end
  end

  always_comb begin
    stateNext   = state;
    hsDec       = HS_ABSENT;
    hsEx        = HS_ABSENT;
    strobes     = '0;
    strobes.idx = regIdxQ;
    case (state)
      ST_IDLE: begin
        if (!reqN) stateNext = ST_EXEC1;
      end
      ST_EXEC1: begin
        if (match) hsDec = (BUSY_WAIT == 0) ? HS_LAST : HS_WAIT;
        if (match && !reqN && condPass)
          stateNext = (BUSY_WAIT == 0) ? ST_MEM : ST_EXECW;
        else
          stateNext = ST_IDLE;
      end
      ST_EXECW: begin
        if (waitCnt == '0) begin
          hsEx      = HS_LAST;
          stateNext = ST_MEM;
        end else begin
          hsEx = HS_WAIT;
        end
      end
      ST_MEM: begin
        strobes.rdEn = isReadQ;
        stateNext    = ST_WRITE;
      end
      ST_WRITE: begin
        strobes.wrEn = !isReadQ;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/cpxfer_regs.sv
module cpxfer_regs
  import cpxfer_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regs[gi] <= '0;
      end else if (strobes.wrEn && strobes.idx == REG_IDX_W'(gi)) begin
        regs[gi] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdEn) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strobes.idx == REG_IDX_W'(i)) rdData = regs[i];
      end
    end
  end

endmodule

// File: rtl/cpxfer_top.sv
module cpxfer_top
  import cpxfer_pkg::*;
#(
  parameter int         NUM_REGS  = 8,
  parameter int         DATA_W    = 32,
  parameter logic [3:0] COPROC_ID = 4'hA,
  parameter int         BUSY_WAIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqN,
  input  logic [31:0]       instr,
  input  logic              condPass,
  input  logic [DATA_W-1:0] wrData,
  output logic [1:0]        hsDec,
  output logic [1:0]        hsEx,
  output logic [DATA_W-1:0] rdData
);

  strobes_t strobes;
  hsCode_t  hsDecCode, hsExCode;

  cpxfer_ctrl #(
    .NUM_REGS (NUM_REGS),
    .COPROC_ID(COPROC_ID),
    .BUSY_WAIT(BUSY_WAIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqN    (reqN),
    .instr   (instr),
    .condPass(condPass),
    .hsDec   (hsDecCode),
    .hsEx    (hsExCode),
    .strobes (strobes)
  );

  cpxfer_regs #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (wrData),
    .rdData (rdData)
  );

  assign hsDec = hsDecCode;
  assign hsEx  = hsExCode;

endmodule

// File: rtl/cpxfer_chk.sv
module cpxfer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqN,
  input logic              condPass,
  input logic [1:0]        hsDec,
  input logic [1:0]        hsEx,
  input logic [DATA_W-1:0] rdData
);

  AST_DEC_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (hsDec != 2'b00) |-> $past(!reqN)); // R2

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (hsDec != 2'b00 && !condPass) |=> (hsEx == 2'b00 && rdData == '0)); // R3

  AST_EX_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (hsEx != 2'b00) |-> $past(hsEx == 2'b01 || (hsDec == 2'b01 && condPass && !reqN))); // R4

  AST_RD_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (rdData != '0) |-> $past(hsEx == 2'b11 || (hsDec == 2'b11 && condPass && !reqN))); // R6

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(hsDec != 2'b00 && hsEx != 2'b00)); // R9

endmodule

bind cpxfer_top cpxfer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqN    (reqN),
  .condPass(condPass),
  .hsDec   (hsDec),
  .hsEx    (hsEx),
  .rdData  (rdData)
);

// File: tb/tb_cpxfer_top.sv
`timescale 1ns/1ps
module tb_cpxfer_top;

  localparam int         BW   = 3;
  localparam int         NREG = 8;
  localparam logic [3:0] CPID = 4'hA;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqN = 1'b1;
  logic [31:0] instr = '0;
  logic        condPass = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  hsDec, hsEx;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [NREG];

  always #4 clk = ~clk;

  cpxfer_top #(
    .NUM_REGS (NREG),
    .DATA_W   (32),
    .COPROC_ID(CPID),
    .BUSY_WAIT(BW)
  ) dut (
    .clk(clk), .rstN(rstN), .reqN(reqN), .instr(instr), .condPass(condPass),
    .wrData(wrData), .hsDec(hsDec), .hsEx(hsEx), .rdData(rdData)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit rd, input logic [3:0] idx,
                                     input logic [3:0] cp);
    return {4'hE, 4'hE, 3'b001, rd, idx, 4'h3, cp, 3'b010, 1'b1, 4'h0};
  endfunction

  task automatic xfer(input logic [31:0] ins, input bit pass,
                      input logic [31:0] wd, input bit jam, input string tag);
    bit          ok;
    int          waits;
    bit          sawLast;
    logic [1:0]  decExp;
    logic [31:0] rdExp;
    int          idx;
    idx = int'(ins[19:16]);
    @(negedge clk);
    reqN = 1'b0; instr = ins; condPass = 1'b0; wrData = ~wd;
    @(negedge clk);
    ok     = (ins[11:8] == CPID) && (idx < NREG);
    decExp = !ok ? 2'b00 : ((BW == 0) ? 2'b11 : 2'b01);
    check("R2", "decode answer", 32'(hsDec), 32'(decExp));
    reqN = 1'b0; condPass = pass; instr = 32'h0;
    if (!ok || !pass) begin
      @(negedge clk);
      reqN = 1'b1; condPass = 1'b0;
      check("R3", "dropped dec bus", 32'(hsDec), 32'h0);
      check("R3", "dropped ex bus", 32'(hsEx), 32'h0);
      check("R3", "dropped rdData", rdData, 32'h0);
      return;
    end
    waits   = (BW == 0) ? 0 : 1;
    sawLast = (BW == 0);
    if (BW != 0) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        reqN = 1'b1; condPass = 1'b0;
        check("R9", "dec bus idle in stall", 32'(hsDec), 32'h0);
        if (hsEx == 2'b11) begin sawLast = 1'b1; break; end
        if (hsEx == 2'b01) waits++;
        else break;
      end
    end
    check("R4", "WAIT count", 32'(waits), 32'(BW));
    check("R4", "LAST seen", 32'(sawLast), 32'h1);
    // memory stage
    @(negedge clk);
    reqN = 1'b1; condPass = 1'b0;
    rdExp = ins[20] ? model[idx] : 32'h0;
    check(ins[20] ? "R6" : "R7", {tag, " mem-stage rdData"}, rdData, rdExp);
    check("R9", "ex bus after LAST", 32'(hsEx), 32'h0);
    if (jam) begin reqN = 1'b0; instr = mk(1'b0, 4'd0, CPID); end
    // write stage
    @(negedge clk);
    wrData = wd;
    check("R6", "rdData after mem stage", rdData, 32'h0);
    if (jam) check("R8", "no decode in write stage", 32'(hsDec), 32'h0);
    // back to idle
    @(negedge clk);
    reqN = 1'b1; wrData = ~wd; instr = 32'h0;
    if (jam) check("R8", "no decode after jam", 32'(hsDec), 32'h0);
    if (!ins[20]) model[idx] = wd;
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "dec bus after reset", 32'(hsDec), 32'h0);
    check("R1", "ex bus after reset", 32'(hsEx), 32'h0);
    check("R1", "rdData after reset", rdData, 32'h0);
    for (int i = 0; i < NREG; i++) xfer(mk(1'b1, 4'(i), CPID), 1'b1, '0, 1'b0, "R1");
    for (int i = 0; i < NREG; i++)
      xfer(mk(1'b0, 4'(i), CPID), 1'b1, 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101) ^ (32'(i) << 4),
           1'b0, "R5");
    for (int i = 0; i < NREG; i++) xfer(mk(1'b1, 4'(i), CPID), 1'b1, '0, 1'b0, "R5");
    xfer(mk(1'b0, 4'd2, CPID), 1'b0, 32'hDEAD_0002, 1'b0, "R3");
    xfer(mk(1'b1, 4'd2, CPID), 1'b0, '0, 1'b0, "R3");
    xfer(mk(1'b1, 4'd2, CPID), 1'b1, '0, 1'b0, "R3");
    xfer(mk(1'b0, 4'd3, CPID ^ 4'h1), 1'b1, 32'hBEEF_0003, 1'b0, "R2");
    xfer(mk(1'b1, 4'd3, CPID), 1'b1, '0, 1'b0, "R2");
    for (int i = NREG; i < 16; i++) xfer(mk(1'b0, 4'(i), CPID), 1'b1, 32'hC0DE_0000 + 32'(i), 1'b0, "R2");
    for (int i = 0; i < NREG; i++) xfer(mk(1'b1, 4'(i), CPID), 1'b1, '0, 1'b0, "R7");
    xfer(mk(1'b0, 4'd5, CPID), 1'b1, 32'h1234_5678, 1'b1, "R8");
    xfer(mk(1'b1, 4'd0, CPID), 1'b1, '0, 1'b0, "R8");
    xfer(mk(1'b1, 4'd5, CPID), 1'b1, '0, 1'b0, "R5");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule